// File: doc/BRIEF.md
# Reservation-Station Issue Scheduler

This block holds dispatched micro-ops until they can be sent to an execution unit. Each entry carries a micro-op identifier, a resource group number and a set of source tags. An entry whose sources are all available on arrival becomes eligible straight away. Otherwise it waits. A broadcast of a completed result tag marks matching sources as available, and once every source of a waiting entry is available, that entry becomes eligible.

In each cycle, at most one eligible entry is issued: the oldest one whose resource group has a unit free. Inside that group, a rotating pointer picks the unit, so that work is spread over the group's units. An issued entry keeps its slot until a writeback names that slot. The slot is then released, and the retire side receives the identifier one cycle later.

The block reports when it is full, how many slots are in use and the highest number of slots in use since reset.

Top module: `iss_sched_top`

## Requirements
- R1: A micro-op whose sources are all available on arrival is never issued in the cycle it is dispatched. It is offered on the issue port in the cycle that follows.
- R2: A micro-op dispatched with any source unavailable is not issued until every one of its sources has become available.
- R3: A wakeup whose tag equals a stored source tag marks that source available. A wakeup in the same cycle as a dispatch also counts for the incoming sources. An entry whose last source is woken is offered on the issue port in the cycle after the wakeup. A wakeup with a non-matching tag has no effect. Source s occupies bits [s*TAG_W +: TAG_W] of the dispatch tag bus and bit s of the readiness bus.
- R4: When several entries are eligible, the one dispatched earliest is issued first, whatever slot it occupies.
- R5: An entry whose group has every unit busy is not issued, and a younger eligible entry of another group issues in its place. Unit u of group g is bit g*UPG+u of the busy input.
- R6: Within a group, the granted unit is the first non-busy unit found by scanning from the group's pointer upward, wrapping around. The pointer moves to the unit after the granted one only when a grant is made in that group. Pointers start at unit 0.
- R7: A writeback naming an issued slot frees that slot and raises the retire output with that micro-op's identifier in the next cycle. A writeback naming a slot that is not in the issued state is ignored.
- R8: The full output is high exactly when no slot is free. A dispatch presented while full is dropped. A slot freed by writeback can accept a dispatch in the very next cycle.
- R9: The occupancy count equals the number of slots in use. The peak output holds the largest count seen since reset.
- R10: After reset, no issue or retire is signalled, the count and peak are zero and full is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A micro-op is presented for dispatch |
| disp_id | input | ID_W | Identifier of the micro-op |
| disp_grp | input | GRP_W | Resource group the micro-op needs |
| disp_src_tag | input | NSRC*TAG_W | Source tags, source s at bits s*TAG_W |
| disp_src_rdy | input | NSRC | Per-source availability on arrival |
| disp_full | output | 1 | No free slot; dispatch is dropped |
| wake_valid | input | 1 | A result tag is broadcast |
| wake_tag | input | TAG_W | Broadcast tag |
| unit_busy | input | NGRP*UPG | Busy flag per unit, group-major |
| iss_valid | output | 1 | A micro-op issues at the coming edge |
| iss_id | output | ID_W | Identifier of the issuing micro-op |
| iss_slot | output | SLOT_W | Slot of the issuing micro-op, returned at writeback |
| iss_grp | output | GRP_W | Group of the issuing micro-op |
| iss_unit | output | UNIT_W | Unit chosen within the group |
| wb_valid | input | 1 | Writeback of an issued micro-op |
| wb_slot | input | SLOT_W | Slot being written back |
| ret_valid | output | 1 | Retire notification |
| ret_id | output | ID_W | Identifier being retired |
| occ_count | output | CNT_W | Slots currently in use |
| occ_peak | output | CNT_W | Highest slot use since reset |

## Verification
A corrupted age relation shows up as micro-ops issuing in slot order instead of arrival order. A directed case places a younger micro-op in a lower slot, so the wrong order appears on the issue identifier within two cycles of the shared wakeup. A pointer that advances without a grant, or that skips a busy unit wrongly, changes the unit index on the next issue to that group. A lost slot state appears at once on the count, full and retire outputs. A lost wakeup leaves the issue port idle in the cycle where an issue was due.

// File: rtl/iss_sched_pkg.sv
package iss_sched_pkg;

  typedef enum logic [1:0] {
    ENT_FREE   = 2'd0,
    ENT_WAIT   = 2'd1,
    ENT_READY  = 2'd2,
    ENT_ISSUED = 2'd3
  } ent_state_e;

  function automatic int width_of(input int count);
    return (count <= 2) ? 1 : $clog2(count);
  endfunction

endpackage

// File: rtl/iss_age_matrix.sv
module iss_age_matrix #(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [SW-1:0] alloc_idx,
  input  logic [N-1:0]  live,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt
);

  // older_q[a][b] set: entry a arrived before entry b
  logic [N-1:0] older_q [N];
  logic [N-1:0] older_d [N];
  logic [N-1:0] blocked;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (alloc_en && (alloc_idx == SW'(i))) begin
          older_d[i][j] = 1'b0;
        end else if (alloc_en && (alloc_idx == SW'(j))) begin
          older_d[i][j] = live[i];
        end else begin
          older_d[i][j] = older_q[i][j];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if ((j != i) && req[j] && older_q[j][i]) begin
          blocked[i] = 1'b1;
        end
      end
      gnt[i] = req[i] && !blocked[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        older_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        older_q[i] <= older_d[i];
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R4

  for (genvar a = 0; a < N; a++) begin : g_row
    for (genvar b = a + 1; b < N; b++) begin : g_col
      AST_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (live[a] && live[b]) |-> (older_q[a][b] != older_q[b][a])); // R4
    end
  end

endmodule

// File: rtl/iss_rr_pick.sv
module iss_rr_pick #(
  parameter int U  = 3,
  parameter int UW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [U-1:0]  busy,
  input  logic          take,
  output logic          avail,
  output logic [UW-1:0] unit
);

  logic [UW-1:0] ptr_q;
  logic [UW-1:0] ptr_d;

  always_comb begin
    avail = 1'b0;
    unit  = '0;
    for (int k = 0; k < U; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= U) begin
        idx = idx - U;
      end
      if (!avail && !busy[idx]) begin
        avail = 1'b1;
        unit  = UW'(idx);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (take) begin
      ptr_d = (unit == UW'(U - 1)) ? '0 : unit + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (take) begin
      ptr_q <= ptr_d;
    end
  end

  AST_RR_TAKE_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> avail); // R5
  AST_RR_FREE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    avail |-> !busy[unit]); // R6
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(ptr_q)); // R6

endmodule

// File: rtl/iss_sched_top.sv
module iss_sched_top
  import iss_sched_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NSRC    = 2,
  parameter int TAG_W   = 6,
  parameter int ID_W    = 8,
  parameter int NGRP    = 2,
  parameter int UPG     = 3,
  localparam int SLOT_W = width_of(ENTRIES),
  localparam int GRP_W  = width_of(NGRP),
  localparam int UNIT_W = width_of(UPG),
  localparam int CNT_W  = $clog2(ENTRIES + 1),
  localparam int NUNIT  = NGRP * UPG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_valid,
  input  logic [ID_W-1:0]       disp_id,
  input  logic [GRP_W-1:0]      disp_grp,
  input  logic [NSRC*TAG_W-1:0] disp_src_tag,
  input  logic [NSRC-1:0]       disp_src_rdy,
  output logic                  disp_full,
  input  logic                  wake_valid,
  input  logic [TAG_W-1:0]      wake_tag,
  input  logic [NUNIT-1:0]      unit_busy,
  output logic                  iss_valid,
  output logic [ID_W-1:0]       iss_id,
  output logic [SLOT_W-1:0]     iss_slot,
  output logic [GRP_W-1:0]      iss_grp,
  output logic [UNIT_W-1:0]     iss_unit,
  input  logic                  wb_valid,
  input  logic [SLOT_W-1:0]     wb_slot,
  output logic                  ret_valid,
  output logic [ID_W-1:0]       ret_id,
  output logic [CNT_W-1:0]      occ_count,
  output logic [CNT_W-1:0]      occ_peak
);

  ent_state_e       st_q  [ENTRIES];
  ent_state_e       st_d  [ENTRIES];
  logic [NSRC-1:0]  rdy_q [ENTRIES];
  logic [NSRC-1:0]  rdy_d [ENTRIES];
  logic [TAG_W-1:0] tag_q [ENTRIES][NSRC];
  logic [GRP_W-1:0] grp_q [ENTRIES];
  logic [ID_W-1:0]  id_q  [ENTRIES];

  logic                free_found;
  logic [SLOT_W-1:0]   alloc_idx;
  logic                alloc_en;
  logic [NSRC-1:0]     in_rdy;
  logic [ENTRIES-1:0]  live;
  logic [ENTRIES-1:0]  elig;
  logic [ENTRIES-1:0]  gnt;
  logic [ENTRIES-1:0]  wb_sel;
  logic [NGRP-1:0]     grp_avail;
  logic [UNIT_W-1:0]   grp_unit [NGRP];
  logic [NGRP-1:0]     grp_take;
  logic                ret_valid_d;
  logic [ID_W-1:0]     ret_id_d;
  logic [CNT_W-1:0]    cnt_d;
  logic [CNT_W-1:0]    peak_q;

  // lowest free slot takes the next dispatch
  always_comb begin
    free_found = 1'b0;
    alloc_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!free_found && (st_q[i] == ENT_FREE)) begin
        free_found = 1'b1;
        alloc_idx  = SLOT_W'(i);
      end
    end
  end

  assign disp_full = !free_found;
  assign alloc_en  = disp_valid && free_found;

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      in_rdy[s] = disp_src_rdy[s] ||
                  (wake_valid && (disp_src_tag[s*TAG_W +: TAG_W] == wake_tag));
    end
  end

  // eligibility: ready and the entry's group has a free unit
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      live[i] = (st_q[i] != ENT_FREE);
      elig[i] = 1'b0;
      for (int g = 0; g < NGRP; g++) begin
        if ((st_q[i] == ENT_READY) && (grp_q[i] == GRP_W'(g))) begin
          elig[i] = grp_avail[g];
        end
      end
    end
  end

  iss_age_matrix #(
    .N  (ENTRIES),
    .SW (SLOT_W)
  ) age_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_idx (alloc_idx),
    .live      (live),
    .req       (elig),
    .gnt       (gnt)
  );

  always_comb begin
    iss_slot = '0;
    iss_grp  = '0;
    iss_id   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (gnt[i]) begin
        iss_slot = SLOT_W'(i);
        iss_grp  = grp_q[i];
        iss_id   = id_q[i];
      end
    end
  end

  assign iss_valid = |gnt;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_take[g] = iss_valid && (iss_grp == GRP_W'(g));
    iss_rr_pick #(
      .U  (UPG),
      .UW (UNIT_W)
    ) rr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (unit_busy[g*UPG +: UPG]),
      .take  (grp_take[g]),
      .avail (grp_avail[g]),
      .unit  (grp_unit[g])
    );
  end

  always_comb begin
    iss_unit = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (iss_grp == GRP_W'(g)) begin
        iss_unit = grp_unit[g];
      end
    end
  end

  // writeback selection and retire notification
  always_comb begin
    ret_valid_d = 1'b0;
    ret_id_d    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      wb_sel[i] = wb_valid && (wb_slot == SLOT_W'(i)) && (st_q[i] == ENT_ISSUED);
      if (wb_sel[i]) begin
        ret_valid_d = 1'b1;
        ret_id_d    = id_q[i];
      end
    end
  end

  // per-entry state transitions
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      st_d[i]  = st_q[i];
      rdy_d[i] = rdy_q[i];
      case (st_q[i])
        ENT_FREE: begin
          if (alloc_en && (alloc_idx == SLOT_W'(i))) begin
            rdy_d[i] = in_rdy;
            st_d[i]  = (&in_rdy) ? ENT_READY : ENT_WAIT;
          end
        end
        ENT_WAIT: begin
          for (int s = 0; s < NSRC; s++) begin
            if (wake_valid && (tag_q[i][s] == wake_tag)) begin
              rdy_d[i][s] = 1'b1;
            end
          end
          if (&rdy_d[i]) begin
            st_d[i] = ENT_READY;
          end
        end
        ENT_READY: begin
          if (gnt[i]) begin
            st_d[i] = ENT_ISSUED;
          end
        end
        default: begin
          if (wb_sel[i]) begin
            st_d[i] = ENT_FREE;
          end
        end
      endcase
    end
  end

  always_comb begin
    occ_count = '0;
    cnt_d     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      occ_count = occ_count + CNT_W'(live[i]);
      cnt_d     = cnt_d + CNT_W'(st_d[i] != ENT_FREE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        st_q[i]  <= ENT_FREE;
        rdy_q[i] <= '0;
      end
      ret_valid <= 1'b0;
      peak_q    <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        st_q[i]  <= st_d[i];
        rdy_q[i] <= rdy_d[i];
      end
      ret_valid <= ret_valid_d;
      if (cnt_d > peak_q) begin
        peak_q <= cnt_d;
      end
    end
  end

  // payload registers carry no reset; loaded on allocation only
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc_en && (alloc_idx == SLOT_W'(i))) begin
        grp_q[i] <= disp_grp;
        id_q[i]  <= disp_id;
        for (int s = 0; s < NSRC; s++) begin
          tag_q[i][s] <= disp_src_tag[s*TAG_W +: TAG_W];
        end
      end
    end
    if (ret_valid_d) begin
      ret_id <= ret_id_d;
    end
  end

  assign occ_peak = peak_q;

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_full) |=> (occ_count <= $past(occ_count))); // R8
  AST_RET_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(wb_valid)); // R7
  AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_peak >= occ_count); // R9
  AST_ISSUE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !unit_busy[int'(iss_grp) * UPG + int'(iss_unit)]); // R5

endmodule

// File: tb/iss_sched_top_tb_top.sv
module iss_sched_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 6;
  localparam int ID_W  = 8;

  logic        clk;
  logic        rst_n;
  logic        disp_valid;
  logic [7:0]  disp_id;
  logic [0:0]  disp_grp;
  logic [11:0] disp_src_tag;
  logic [1:0]  disp_src_rdy;
  logic        disp_full;
  logic        wake_valid;
  logic [5:0]  wake_tag;
  logic [5:0]  unit_busy;
  logic        iss_valid;
  logic [7:0]  iss_id;
  logic [2:0]  iss_slot;
  logic [0:0]  iss_grp;
  logic [1:0]  iss_unit;
  logic        wb_valid;
  logic [2:0]  wb_slot;
  logic        ret_valid;
  logic [7:0]  ret_id;
  logic [3:0]  occ_count;
  logic [3:0]  occ_peak;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  iss_sched_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_id(disp_id), .disp_grp(disp_grp),
    .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy), .disp_full(disp_full),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .unit_busy(unit_busy),
    .iss_valid(iss_valid), .iss_id(iss_id), .iss_slot(iss_slot),
    .iss_grp(iss_grp), .iss_unit(iss_unit),
    .wb_valid(wb_valid), .wb_slot(wb_slot),
    .ret_valid(ret_valid), .ret_id(ret_id),
    .occ_count(occ_count), .occ_peak(occ_peak)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 20000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // inputs are driven and outputs sampled 1 time unit after the rising edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    disp_valid = 1'b0; disp_id = '0; disp_grp = '0;
    disp_src_tag = '0; disp_src_rdy = '0;
    wake_valid = 1'b0; wake_tag = '0; unit_busy = '0;
    wb_valid = 1'b0; wb_slot = '0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic disp(input int id, input int grp, input int t0, input int r0,
                      input int t1, input int r1);
    disp_valid   = 1'b1;
    disp_id      = ID_W'(id);
    disp_grp     = 1'(grp);
    disp_src_tag = {TAG_W'(t1), TAG_W'(t0)};
    disp_src_rdy = {1'(r1), 1'(r0)};
    tick();
    disp_valid = 1'b0;
  endtask

  task automatic wake(input int tag);
    wake_valid = 1'b1;
    wake_tag   = TAG_W'(tag);
    tick();
    wake_valid = 1'b0;
  endtask

  task automatic wback(input int slot);
    wb_valid = 1'b1;
    wb_slot  = 3'(slot);
    tick();
    wb_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10", "iss_valid", iss_valid, 0);
    chk("R10", "ret_valid", ret_valid, 0);
    chk("R10", "occ_count", occ_count, 0);
    chk("R10", "occ_peak", occ_peak, 0);
    chk("R10", "disp_full", disp_full, 0);
  endtask

  task automatic t_ready_path();
    int slot;
    do_reset();
    disp_valid = 1'b1; disp_id = 8'd5; disp_grp = 1'b0;
    disp_src_tag = {6'd2, 6'd1}; disp_src_rdy = 2'b11;
    #1;
    chk("R1", "no issue in dispatch cycle", iss_valid, 0);
    tick();
    disp_valid = 1'b0;
    chk("R1", "issue next cycle", iss_valid, 1);
    chk("R1", "iss_id", iss_id, 5);
    chk("R6", "first unit", iss_unit, 0);
    chk("R9", "occ_count", occ_count, 1);
    slot = iss_slot;
    tick();
    chk("R1", "issued once", iss_valid, 0);
    wback(3);
    chk("R7", "wb to non-issued slot ignored", ret_valid, 0);
    chk("R7", "count after ignored wb", occ_count, 1);
    wback(slot);
    chk("R7", "ret_valid", ret_valid, 1);
    chk("R7", "ret_id", ret_id, 5);
    chk("R7", "slot freed", occ_count, 0);
    tick();
    chk("R7", "ret pulse ends", ret_valid, 0);
  endtask

  task automatic t_wait_wake();
    do_reset();
    disp(9, 0, 10, 1, 11, 0);
    chk("R2", "waiting entry not issued", iss_valid, 0);
    tick();
    chk("R2", "still waiting", iss_valid, 0);
    wake(12);
    chk("R3", "non-matching wake ignored", iss_valid, 0);
    wake(11);
    chk("R3", "woken entry offered", iss_valid, 1);
    chk("R3", "woken id", iss_id, 9);
    do_reset();
    disp_valid = 1'b1; disp_id = 8'h33; disp_grp = 1'b0;
    disp_src_tag = {6'd0, 6'd21}; disp_src_rdy = 2'b10;
    wake_valid = 1'b1; wake_tag = 6'd21;
    tick();
    disp_valid = 1'b0; wake_valid = 1'b0;
    chk("R3", "same-cycle wake counts", iss_valid, 1);
    chk("R3", "same-cycle wake id", iss_id, 8'h33);
  endtask

  task automatic t_oldest();
    int slot_x;
    do_reset();
    disp(8'h70, 0, 1, 1, 2, 1);
    chk("R6", "unit for first", iss_unit, 0);
    slot_x = iss_slot;
    tick();
    disp(1, 0, 40, 0, 41, 1);
    wback(slot_x);
    disp(2, 0, 40, 0, 41, 1);
    wake(40);
    chk("R4", "oldest first valid", iss_valid, 1);
    chk("R4", "oldest first id", iss_id, 1);
    chk("R6", "rotated unit", iss_unit, 1);
    tick();
    chk("R4", "younger next", iss_id, 2);
    chk("R6", "rotated unit again", iss_unit, 2);
    tick();
    chk("R4", "drained", iss_valid, 0);
  endtask

  task automatic t_round_robin();
    do_reset();
    unit_busy = 6'b001000;
    for (int k = 0; k < 4; k++) begin
      disp(10 + k, 1, 50, 0, 50, 0);
    end
    wake(50);
    chk("R6", "skip busy id", iss_id, 10);
    chk("R6", "skip busy unit", iss_unit, 1);
    chk("R6", "group", iss_grp, 1);
    tick();
    chk("R6", "second unit", iss_unit, 2);
    tick();
    chk("R6", "wrap skip busy", iss_unit, 1);
    tick();
    chk("R6", "fourth unit", iss_unit, 2);
    chk("R6", "fourth id", iss_id, 13);
    tick();
    unit_busy = 6'b111000;
    disp(14, 1, 3, 1, 3, 1);
    chk("R5", "group all busy blocks", iss_valid, 0);
    disp(15, 0, 3, 1, 3, 1);
    chk("R5", "other group bypasses", iss_id, 15);
    chk("R5", "other group unit", iss_grp, 0);
    tick();
    chk("R5", "blocked stays", iss_valid, 0);
    unit_busy = 6'b000000;
    #1;
    chk("R5", "released issues", iss_id, 14);
    chk("R6", "pointer held without grant", iss_unit, 0);
    tick();
  endtask

  task automatic t_full();
    int slot0;
    do_reset();
    for (int k = 0; k < 8; k++) begin
      disp(8'h80 + k, 0, 60, 0, 60, 0);
      chk("R9", "count while filling", occ_count, k + 1);
    end
    chk("R8", "full", disp_full, 1);
    chk("R9", "peak", occ_peak, 8);
    disp(99, 0, 1, 1, 1, 1);
    chk("R8", "dropped dispatch count", occ_count, 8);
    chk("R8", "dropped dispatch no issue", iss_valid, 0);
    wake(60);
    chk("R8", "oldest after wake", iss_id, 8'h80);
    slot0 = iss_slot;
    tick();
    wback(slot0);
    chk("R8", "not full after wb", disp_full, 0);
    chk("R9", "count after wb", occ_count, 7);
    chk("R9", "peak holds", occ_peak, 8);
    disp(8'h90, 0, 1, 1, 1, 1);
    chk("R8", "freed slot reused", occ_count, 8);
    chk("R8", "full again", disp_full, 1);
  endtask

  initial begin
    t_reset();
    t_ready_path();
    t_wait_wake();
    t_oldest();
    t_round_robin();
    t_full();
    finish_run();
  end

endmodule